// File: doc/BRIEF.md
# DMA Bus Mastership Requester

This block sits beside a DMA transfer engine and wins the processor bus for it through a three-wire arbitration handshake. After the engine pulses `start` with a burst length, the block raises a bus request. It then waits for the processor's bus grant. Next it waits until the current master has let go of the address strobe. Only then does it claim the bus by raising a grant-acknowledge. Raising the acknowledge also withdraws the request.

While the acknowledge is high, `bus_owned` enables the engine's address and data drivers. The engine pulses `xfer_done` once per completed transfer. When the last transfer of the burst is counted, the acknowledge and `bus_owned` drop together. One cycle later `done` pulses to tell the engine that the bus has been handed back. The grant and the address strobe come from another clock domain, so each passes through its own two-flop synchroniser before the controller uses it. All signals are active-high inside the block. Any inversion needed at the pins is done outside it.

Top module: `dma_bus_requester`

## Requirements
- R1: After a synchronous reset, `bus_req`, `grant_ack`, `bus_owned` and `done` are all low.
- R2: A `start` pulse while the block is idle raises `bus_req` at the next clock edge. The length presented on `burst_len` is captured on that edge, and a length of 0 is treated as 1.
- R3: `grant_ack` rises only once the synchronised grant has been seen and the synchronised address strobe is low. If the strobe is already low when the grant arrives, the acknowledge rises on the 4th clock edge after the grant input changes. If the strobe is released while the block is already waiting on it, the acknowledge rises on the 3rd clock edge after the strobe input falls.
- R4: `bus_req` stays high from the start until the edge on which `grant_ack` rises, and it falls on that same edge.
- R5: `bus_owned` is high exactly when `grant_ack` is high.
- R6: `grant_ack` stays high until exactly the effective burst length of `xfer_done` pulses has been counted, and it falls on the edge that samples the last one. `xfer_done` has no effect while the bus is not owned.
- R7: `done` is a single-cycle pulse that is high in the cycle after `grant_ack` falls.
- R8: A `start` pulse while a request or burst is in progress is ignored. It neither changes the current burst's length nor causes a second request after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request from the DMA engine to acquire the bus |
| burst_len | input | LEN_W | Number of transfers in the burst, sampled with `start` (0 means 1) |
| xfer_done | input | 1 | One-cycle pulse per completed transfer while the bus is owned |
| bus_grant | input | 1 | Bus grant from the processor (asynchronous) |
| addr_strobe | input | 1 | Address strobe of the current master, high while active (asynchronous) |
| bus_req | output | 1 | Bus request to the processor |
| grant_ack | output | 1 | Grant acknowledge; holds mastership for the burst |
| bus_owned | output | 1 | Enables the engine's bus drivers |
| done | output | 1 | One-cycle pulse after the bus has been handed back |

## Verification
The assertions assume that the processor keeps its grant high until the acknowledge rises. They also assume that `xfer_done` pulses only while the bus is owned, with the stray idle pulse being the single deliberate exception. Finally, they assume that the address strobe makes no new request once the grant has been given. The stimulus follows these rules while drawing burst lengths from 0 to 15, grant delays, strobe hold times and gaps between transfers from a fixed-seed generator. It then adds directed cases: a zero length, a strobe that is already idle, a stray idle `xfer_done`, and a `start` issued mid-burst.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT_AS = 3'd2,
    ST_OWN     = 3'd3,
    ST_RELEASE = 3'd4
  } arb_state_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             is_last
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst)
      remaining <= '0;
    else if (load)
      remaining <= (load_val == '0) ? ONE : load_val;
    else if (dec)
      remaining <= remaining - ONE;
  end

  assign is_last = (remaining == ONE);

  // R6: a transfer is never counted past the end of the burst
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    dec |-> remaining != '0);
endmodule

// File: rtl/dma_bus_requester.sv
module dma_bus_requester
  import dma_arb_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             xfer_done,
  input  logic             bus_grant,
  input  logic             addr_strobe,
  output logic             bus_req,
  output logic             grant_ack,
  output logic             bus_owned,
  output logic             done
);
  arb_state_t state;
  logic [1:0] sync_out;
  logic       grant_s;
  logic       strobe_s;
  logic       cnt_load;
  logic       cnt_dec;
  logic       cnt_last;

  sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_grant, addr_strobe}),
    .q   (sync_out)
  );
  assign grant_s  = sync_out[1];
  assign strobe_s = sync_out[0];

  assign cnt_load = (state == ST_IDLE) && start;
  assign cnt_dec  = (state == ST_OWN) && xfer_done;

  burst_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (burst_len),
    .dec      (cnt_dec),
    .is_last  (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      grant_ack <= 1'b0;
      bus_owned <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          bus_req <= 1'b1;
          state   <= ST_REQ;
        end
        ST_REQ: if (grant_s) state <= ST_WAIT_AS;
        ST_WAIT_AS: if (!strobe_s) begin
          bus_req   <= 1'b0;
          grant_ack <= 1'b1;
          bus_owned <= 1'b1;
          state     <= ST_OWN;
        end
        ST_OWN: if (xfer_done && cnt_last) begin
          grant_ack <= 1'b0;
          bus_owned <= 1'b0;
          state     <= ST_RELEASE;
        end
        ST_RELEASE: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: mastership is claimed only out of the wait state with the strobe idle
  p_ack_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_ack) |-> ($past(state) == ST_WAIT_AS) && !$past(strobe_s));

  // R3: the wait state is entered only once the grant has been seen
  p_wait_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_AS) && ($past(state) != ST_WAIT_AS) |-> $past(grant_s));

  // R4: request and acknowledge are never high together
  p_req_ack_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    grant_ack |-> !bus_req);

  // R5: driver enable follows the acknowledge
  p_owned_is_ack_r5: assert property (@(posedge clk) disable iff (rst)
    bus_owned == grant_ack);

  // R7: completion is one cycle wide and follows the hand-back
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !grant_ack && $past(grant_ack, 2));
endmodule

// File: tb/tb_dma_bus_requester.sv
module tb_dma_bus_requester;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic xfer_done = 1'b0;
  logic bus_grant = 1'b0;
  logic addr_strobe = 1'b0;
  logic bus_req, grant_ack, bus_owned, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_bus_requester #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
    .xfer_done(xfer_done), .bus_grant(bus_grant), .addr_strobe(addr_strobe),
    .bus_req(bus_req), .grant_ack(grant_ack), .bus_owned(bus_owned), .done(done)
  );

  function automatic int eff_len(int len);
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int ack_latency(bit strobe_busy);
    return strobe_busy ? 3 : 4;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic run_burst(int len, int gdelay, bit strobe_busy, int sdelay, bit stray_start, int gapmax);
    int k;
    int pulses;
    @(negedge clk);
    start = 1'b1; burst_len = LEN_W'(len); addr_strobe = strobe_busy;
    @(negedge clk);
    start = 1'b0; burst_len = LEN_W'(15 - len);
    check("R2 bus_req after start", int'(bus_req), 1);
    repeat (gdelay) @(negedge clk);
    check("R4 req held before grant", int'(bus_req), 1);
    check("R3 no ack before grant", int'(grant_ack), 0);
    bus_grant = 1'b1;
    if (strobe_busy) begin
      repeat (3 + sdelay) @(negedge clk);
      check("R3 no ack while strobe busy", int'(grant_ack), 0);
      addr_strobe = 1'b0;
    end
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!grant_ack && k < 20);
    check("R3 ack latency", k, ack_latency(strobe_busy));
    check("R4 req dropped with ack", int'(bus_req), 0);
    check("R5 bus_owned with ack", int'(bus_owned), 1);
    bus_grant = 1'b0;
    if (stray_start) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    pulses = 0;
    while (grant_ack && pulses < 40) begin
      repeat ($urandom_range(gapmax, 0)) @(negedge clk);
      check("R6 ack held until last transfer", int'(grant_ack), 1);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      pulses++;
      check("R5 owned tracks ack", int'(bus_owned), int'(grant_ack));
      if (grant_ack) check("R7 no early done", int'(done), 0);
    end
    check("R6 transfers in burst", pulses, eff_len(len));
    check("R7 done after release", int'(done), 0);
    @(negedge clk);
    check("R7 done pulse", int'(done), 1);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check("R8 no extra request", int'(bus_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 bus_req reset", int'(bus_req), 0);
    check("R1 grant_ack reset", int'(grant_ack), 0);
    check("R1 bus_owned reset", int'(bus_owned), 0);
    check("R1 done reset", int'(done), 0);
    // R6: stray transfer pulse while idle is ignored
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R6 idle xfer_done ignored", int'(grant_ack), 0);
    run_burst(3, 2, 1'b0, 0, 1'b0, 2);
    run_burst(0, 0, 1'b1, 4, 1'b0, 0);   // R2 zero length means one
    run_burst(15, 5, 1'b1, 0, 1'b1, 1);  // R8 stray start mid-burst
    run_burst(1, 1, 1'b0, 0, 1'b1, 0);
    for (int i = 0; i < 40; i++) begin
      run_burst($urandom_range(15, 0), $urandom_range(6, 0), 1'($urandom_range(1, 0)),
                $urandom_range(5, 0), 1'($urandom_range(1, 0)), 3);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule